// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for every incoming Ethernet frame, whether the frame is kept or dropped. Its inputs are the frame length and the six destination address bytes, which arrive one byte per cycle in wire order. The decision depends on the destination class (unicast, multicast or broadcast), the programmed station address, a 64-bit multicast hash table and three mode bits. One cycle after the sixth address byte, the block raises a decision strobe together with an accept bit and a group flag. The group flag marks accepted broadcast and multicast frames.

The hash table is built inside the block. Software starts a load with a byte count, then streams the multicast addresses one byte per cycle. The table is first cleared, and each address sets one bit. The bit is chosen by a CRC-32 of the address bytes. The station address, the mode bits and the minimum frame length are written through a small byte-wide write port.

Top module: `rx_addr_filter`

## Requirements
- R1: Each multicast address gets a hash index. The CRC-32 of its six bytes is computed with reflected polynomial 0xEDB88320, seed all ones, each byte taken LSB first, and the result inverted. The index is bits 7:2 of that result, and it selects one bit of the 64-bit table.
- R2: Asserting `mc_start` clears the whole hash table before any address of the new list is applied. Addresses loaded earlier no longer match.
- R3: The number of addresses processed is `mc_byte_cnt` / 6 (integer division), capped at 64. Address bytes streamed after that number has been consumed leave the table unchanged.
- R4: When mode bit 0 (promiscuous) is set, every frame of sufficient length is accepted with `dec_group` = 0.
- R5: A destination of FF:FF:FF:FF:FF:FF is broadcast. When mode bit 1 (broadcast off) is set it is rejected. Otherwise it is accepted with `dec_group` = 1.
- R6: A destination that is not broadcast and has bit 0 of its first byte set is multicast. It is accepted, with `dec_group` = 1, only when mode bit 2 (multicast enable) is set and the table bit at its R1 index is 1. Otherwise it is rejected.
- R7: A destination with bit 0 of its first byte clear is accepted only if all six bytes equal the station address; it is rejected otherwise, with `dec_group` = 0.
- R8: A frame whose `frm_len` is below the programmed minimum length is rejected, regardless of mode or address. A programmed minimum below 5 is stored as 5, and the minimum after reset is 5.
- R9: `dec_valid` rises in the cycle after the sixth address byte is taken. `dec_valid`, `dec_accept` and `dec_group` then hold until `frm_start`, which drops `dec_valid` in the following cycle. Address bytes beyond the sixth are ignored.
- R10: After reset, `dec_valid`, `dec_accept` and `dec_group` are 0, the station address is all zeros and all mode bits are clear.
- R11: The configuration port has eight slots, and a write takes effect at the clock edge. Slots 0..5 hold station address bytes in wire order (slot 0 is the first byte on the wire). Slot 6 holds the mode bits {mc enable, broadcast off, promiscuous} in bits 2:0. Slot 7 holds the minimum frame length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration slot |
| cfg_wdata | input | 8 | Configuration write data |
| mc_start | input | 1 | Start a multicast list load (clears the table) |
| mc_byte_cnt | input | CNT_W (16) | List length in bytes, sampled with `mc_start` |
| mc_valid | input | 1 | Multicast list byte valid |
| mc_byte | input | 8 | Multicast list byte |
| frm_start | input | 1 | Start of a new frame |
| frm_len | input | LEN_W (16) | Frame length, sampled with `frm_start` |
| da_valid | input | 1 | Destination address byte valid |
| da_byte | input | 8 | Destination address byte, in wire order |
| dec_valid | output | 1 | Decision available |
| dec_accept | output | 1 | Frame accepted |
| dec_group | output | 1 | Accepted frame is broadcast or multicast |

## Verification
The filter is driven with unicast addresses that differ from the station address in exactly one byte at each of the six positions. This shows that every byte takes part in the compare. Two sweeps of 128 multicast addresses are checked against a bench-built hash table, one with multicast enabled and one with it disabled. This separates a wrong CRC index or bit order from a wrong mode gate. List loads of one address, of a non-multiple byte count and of more than 64 addresses are compared with shorter lists, which shows the clearing, the divide-by-six and the cap. Broadcast under both settings of the broadcast-off bit, promiscuous mode, and frames at and just under the minimum length complete the cases.

// File: rtl/rxf_pkg.sv
// Shared constants, mode type and CRC bit step for the receive address filter.
package rxf_pkg;
    localparam int          ADDR_BYTES    = 6;
    localparam logic [31:0] CRC_POLY      = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [7:0]  MIN_LEN_FLOOR = 8'd5;

    // Mode bits as stored in configuration slot 6.
    typedef struct packed {
        logic mc_en;
        logic bc_off;
        logic promisc;
    } rxf_mode_t;

    // One reflected CRC-32 step for a single input bit.
    function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic d);
        logic fb;
        fb = c[0] ^ d;
        return fb ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    endfunction
endpackage

// File: rtl/rxf_crc_byte.sv
// Byte-wide reflected CRC-32 accumulator.
// Assumes: byte bits are consumed LSB first; restart seeds from all ones
// for the byte presented in the same cycle. crc_next is the raw (not inverted) value.
module rxf_crc_byte
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    input  logic        restart,
    input  logic [7:0]  data,
    output logic [31:0] crc_next
);
    logic [31:0] crc_q;
    logic [31:0] chain [0:8];

    assign chain[0] = restart ? CRC_SEED : crc_q;

    // Unrolled bit chain, one stage per data bit.
    for (genvar i = 0; i < 8; i++) begin : g_bit
        assign chain[i+1] = crc_bit(chain[i], data[i]);
    end

    assign crc_next = chain[8];

    // Keep the running remainder between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= CRC_SEED;
        else if (step) crc_q <= crc_next;
    end
endmodule

// File: rtl/rxf_cfg_regs.sv
// Configuration store: station address bytes, mode bits, minimum frame length.
// Assumes: slots 0..ADDR_BYTES-1 are address bytes in wire order, the next slot
// holds the mode bits, and the slot after it holds the minimum length (floored).
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int CFG_AW = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [CFG_AW-1:0]                waddr,
    input  logic [7:0]                       wdata,
    output logic [ADDR_BYTES-1:0][7:0]       station,
    output rxf_mode_t                        mode,
    output logic [7:0]                       min_len
);
    localparam logic [CFG_AW-1:0] MODE_SLOT = CFG_AW'(ADDR_BYTES);
    localparam logic [CFG_AW-1:0] MIN_SLOT  = CFG_AW'(ADDR_BYTES + 1);

    // One register per station address byte.
    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_sta
        always_ff @(posedge clk) begin
            if (!rst_n)                              station[i] <= '0;
            else if (we && waddr == CFG_AW'(i))      station[i] <= wdata;
        end
    end

    // Mode bits and floored minimum length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= '0;
            min_len <= MIN_LEN_FLOOR;
        end else if (we) begin
            if (waddr == MODE_SLOT) mode <= rxf_mode_t'(wdata[2:0]);
            if (waddr == MIN_SLOT)  min_len <= (wdata < MIN_LEN_FLOOR) ? MIN_LEN_FLOOR : wdata;
        end
    end
endmodule

// File: rtl/rxf_mc_table.sv
// Multicast hash table builder.
// Assumes: load_start clears the table and samples the byte count; list bytes
// follow in wire order; bytes presented together with load_start are dropped.
module rxf_mc_table
    import rxf_pkg::*;
#(
    parameter int ENTRIES   = 64,
    parameter int MAX_ADDRS = 64,
    parameter int CNT_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_start,
    input  logic [CNT_W-1:0]   load_bytes,
    input  logic               byte_valid,
    input  logic [7:0]         byte_data,
    output logic [ENTRIES-1:0] table_bits
);
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int LEFT_W = $clog2(MAX_ADDRS + 1);
    localparam int POS_W  = $clog2(ADDR_BYTES + 1);

    logic [CNT_W-1:0]  addr_cnt;
    logic [LEFT_W-1:0] left_q;
    logic [POS_W-1:0]  pos_q;
    logic              take, last;
    logic [31:0]       crc_next, hash;
    logic [IDX_W-1:0]  idx;

    assign addr_cnt = load_bytes / CNT_W'(ADDR_BYTES);
    assign take     = byte_valid && !load_start && (left_q != '0);
    assign last     = take && (pos_q == POS_W'(ADDR_BYTES - 1));

    rxf_crc_byte u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (take),
        .restart  (pos_q == '0),
        .data     (byte_data),
        .crc_next (crc_next)
    );

    assign hash = ~crc_next;
    assign idx  = hash[IDX_W+1:2];

    // Track remaining addresses and byte position within the current address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            pos_q  <= '0;
        end else if (load_start) begin
            left_q <= (addr_cnt > CNT_W'(MAX_ADDRS)) ? LEFT_W'(MAX_ADDRS) : LEFT_W'(addr_cnt);
            pos_q  <= '0;
        end else if (take) begin
            pos_q <= last ? '0 : pos_q + 1'b1;
            if (last) left_q <= left_q - 1'b1;
        end
    end

    // Clear on load start, set one hashed bit per completed address.
    always_ff @(posedge clk) begin
        if (!rst_n)          table_bits <= '0;
        else if (load_start) table_bits <= '0;
        else if (last)       table_bits[idx] <= 1'b1;
    end
endmodule

// File: rtl/rx_addr_filter.sv
// Receive address filter top: classifies the destination address and issues
// one registered accept/reject decision per frame.
// Assumes: frm_start precedes the address bytes; frm_len is valid with frm_start;
// mode and table are stable while a frame's address is arriving.
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int LEN_W        = 16,
    parameter int CNT_W        = 16,
    parameter int HASH_ENTRIES = 64,
    parameter int MAX_MC       = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    input  logic             mc_start,
    input  logic [CNT_W-1:0] mc_byte_cnt,
    input  logic             mc_valid,
    input  logic [7:0]       mc_byte,
    input  logic             frm_start,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             da_valid,
    input  logic [7:0]       da_byte,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             dec_group
);
    localparam int IDX_W = $clog2(HASH_ENTRIES);
    localparam int POS_W = $clog2(ADDR_BYTES + 1);

    logic [ADDR_BYTES-1:0][7:0] station;
    rxf_mode_t                  mode;
    logic [7:0]                 min_len;
    logic [HASH_ENTRIES-1:0]    mc_bits;

    logic [POS_W-1:0] pos_q;
    logic             short_q, match_q, ones_q, grp_q;
    logic             take, last;
    logic [7:0]       sta_byte;
    logic             match_n, ones_n, grp_n;
    logic [31:0]      crc_next, hash;
    logic [IDX_W-1:0] idx;
    logic             acc_n, flag_n;

    rxf_cfg_regs #(.CFG_AW(3)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .waddr   (cfg_addr),
        .wdata   (cfg_wdata),
        .station (station),
        .mode    (mode),
        .min_len (min_len)
    );

    rxf_mc_table #(.ENTRIES(HASH_ENTRIES), .MAX_ADDRS(MAX_MC), .CNT_W(CNT_W)) u_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_start (mc_start),
        .load_bytes (mc_byte_cnt),
        .byte_valid (mc_valid),
        .byte_data  (mc_byte),
        .table_bits (mc_bits)
    );

    assign take = da_valid && !frm_start && (pos_q < POS_W'(ADDR_BYTES));
    assign last = take && (pos_q == POS_W'(ADDR_BYTES - 1));

    rxf_crc_byte u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (take),
        .restart  (pos_q == '0),
        .data     (da_byte),
        .crc_next (crc_next)
    );

    assign hash = ~crc_next;
    assign idx  = hash[IDX_W+1:2];

    // Per-byte comparisons folded into the running flags.
    always_comb begin
        sta_byte = (pos_q < POS_W'(ADDR_BYTES)) ? station[pos_q] : 8'h00;
        match_n  = match_q && (da_byte == sta_byte);
        ones_n   = ones_q && (da_byte == 8'hFF);
        grp_n    = (pos_q == '0) ? da_byte[0] : grp_q;
    end

    // Classification once the last address byte is present.
    always_comb begin
        acc_n  = 1'b0;
        flag_n = 1'b0;
        if (short_q) begin
            acc_n = 1'b0;
        end else if (mode.promisc) begin
            acc_n = 1'b1;
        end else if (ones_n) begin
            acc_n  = !mode.bc_off;
            flag_n = !mode.bc_off;
        end else if (grp_n) begin
            acc_n  = mode.mc_en && mc_bits[idx];
            flag_n = acc_n;
        end else begin
            acc_n = match_n;
        end
    end

    // Frame state and held decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q      <= '0;
            short_q    <= 1'b0;
            match_q    <= 1'b1;
            ones_q     <= 1'b1;
            grp_q      <= 1'b0;
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_group  <= 1'b0;
        end else if (frm_start) begin
            pos_q      <= '0;
            short_q    <= frm_len < LEN_W'(min_len);
            match_q    <= 1'b1;
            ones_q     <= 1'b1;
            grp_q      <= 1'b0;
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_group  <= 1'b0;
        end else if (take) begin
            pos_q   <= pos_q + 1'b1;
            match_q <= match_n;
            ones_q  <= ones_n;
            grp_q   <= grp_n;
            if (last) begin
                dec_valid  <= 1'b1;
                dec_accept <= acc_n;
                dec_group  <= flag_n;
            end
        end
    end
endmodule

// File: rtl/rx_addr_filter_chk.sv
// Property checker for rx_addr_filter, attached by bind below.
// Assumes: reset is synchronous active low; table_bits is the internal hash table.
module rx_addr_filter_chk #(
    parameter int ENTRIES = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frm_start,
    input logic               da_valid,
    input logic               mc_start,
    input logic               dec_valid,
    input logic               dec_accept,
    input logic               dec_group,
    input logic [ENTRIES-1:0] table_bits
);
    p_clear_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start |=> !dec_valid);

    p_hold_decision_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !frm_start) |=> (dec_valid && $stable(dec_accept) && $stable(dec_group)));

    p_rise_after_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) |-> $past(da_valid));

    p_group_needs_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_group) |-> dec_accept);

    p_table_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mc_start |=> (table_bits == '0));
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.ENTRIES(HASH_ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_start  (frm_start),
    .da_valid   (da_valid),
    .mc_start   (mc_start),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_group  (dec_group),
    .table_bits (mc_bits)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        mc_start = 1'b0;
    logic [15:0] mc_byte_cnt = '0;
    logic        mc_valid = 1'b0;
    logic [7:0]  mc_byte = '0;
    logic        frm_start = 1'b0;
    logic [15:0] frm_len = '0;
    logic        da_valid = 1'b0;
    logic [7:0]  da_byte = '0;
    logic        dec_valid, dec_accept, dec_group;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench-side model state.
    logic [47:0] m_sta = '0;
    logic [2:0]  m_mode = '0;
    int          m_min = 5;
    logic [63:0] m_tab = '0;

    always #2 clk = ~clk;

    rx_addr_filter i_rx_addr_filter (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
        .mc_start, .mc_byte_cnt, .mc_valid, .mc_byte,
        .frm_start, .frm_len, .da_valid, .da_byte,
        .dec_valid, .dec_accept, .dec_group
    );

    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int b = 0; b < 6; b++) begin
            c = c ^ {24'h0, a[47-8*b -: 8]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic int ref_idx(input logic [47:0] a);
        logic [31:0] h = ref_crc(a);
        return int'(h[7:2]);
    endfunction

    function automatic logic [47:0] mc_addr(input int k);
        logic [15:0] kk = 16'(k);
        return {8'h01, 8'h00, 8'h5E, 8'h00, kk};
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual {valid,accept,group}=%b expected %b", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int slot, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(slot); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (slot < 6) m_sta[47-8*slot -: 8] = v;
        else if (slot == 6) m_mode = v[2:0];
        else m_min = (v < 5) ? 5 : int'(v);
    endtask

    task automatic mc_load(input int cnt, input int n, input int base);
        int lim;
        @(negedge clk);
        mc_start = 1'b1; mc_byte_cnt = 16'(cnt);
        @(negedge clk);
        mc_start = 1'b0;
        for (int j = 0; j < n; j++) begin
            for (int b = 0; b < 6; b++) begin
                logic [47:0] a = mc_addr(base + j);
                mc_valid = 1'b1; mc_byte = a[47-8*b -: 8];
                @(negedge clk);
            end
        end
        mc_valid = 1'b0;
        m_tab = '0;
        lim = cnt / 6;
        if (lim > 64) lim = 64;
        for (int j = 0; j < n && j < lim; j++) m_tab[ref_idx(mc_addr(base + j))] = 1'b1;
    endtask

    function automatic logic [2:0] model(input logic [47:0] da, input int len);
        logic acc = 1'b0, grp = 1'b0;
        if (len < m_min) acc = 1'b0;
        else if (m_mode[0]) acc = 1'b1;
        else if (da == 48'hFFFF_FFFF_FFFF) begin acc = !m_mode[1]; grp = acc; end
        else if (da[40]) begin acc = m_mode[2] && m_tab[ref_idx(da)]; grp = acc; end
        else acc = (da == m_sta);
        return {1'b1, acc, grp};
    endfunction

    // Send a frame and check the decision the cycle after the sixth byte.
    task automatic send(input string req, input logic [47:0] da, input int len);
        @(negedge clk);
        frm_start = 1'b1; frm_len = 16'(len);
        @(negedge clk);
        frm_start = 1'b0;
        for (int b = 0; b < 6; b++) begin
            da_valid = 1'b1; da_byte = da[47-8*b -: 8];
            @(negedge clk);
        end
        da_valid = 1'b0;
        check(req, {dec_valid, dec_accept, dec_group}, model(da, len));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state of outputs
        check("R10 reset outputs", {dec_valid, dec_accept, dec_group}, 3'b000);
        // R10: station reset to zero matches a zero unicast destination
        send("R10 zero station", 48'h0, 60);

        // R11: program station and min length
        cfg_write(0, 8'h02); cfg_write(1, 8'h11); cfg_write(2, 8'h22);
        cfg_write(3, 8'h33); cfg_write(4, 8'h44); cfg_write(5, 8'h55);
        cfg_write(7, 8'd60);
        send("R11 R7 station match", 48'h0211_2233_4455, 64);
        // R7: single-byte mismatch at each position
        for (int p = 0; p < 6; p++) send("R7 byte mismatch", m_sta ^ (48'h1 << (8*p + 1)), 64);
        send("R7 unrelated unicast", 48'h0A0B_0C0D_0E0F, 64);

        // R5: broadcast with and without broadcast-off
        send("R5 broadcast accepted", 48'hFFFF_FFFF_FFFF, 64);
        cfg_write(6, 8'h02);
        send("R5 broadcast off", 48'hFFFF_FFFF_FFFF, 64);

        // R1 R6: one-address table, sweep with multicast disabled then enabled
        cfg_write(6, 8'h00);
        mc_load(6, 1, 5);
        send("R6 mc disabled", mc_addr(5), 64);
        for (int k = 0; k < 128; k++) send("R6 sweep mc off", mc_addr(k), 64);
        cfg_write(6, 8'h04);
        send("R1 loaded address hits", mc_addr(5), 64);
        for (int k = 0; k < 128; k++) send("R1 R6 sweep one entry", mc_addr(k), 64);

        // R3: count not a multiple of six, extra address streamed
        mc_load(41, 7, 20);
        for (int k = 0; k < 128; k++) send("R3 divide by six", mc_addr(k), 64);

        // R2: reload with one address clears previous bits
        mc_load(6, 1, 90);
        for (int k = 20; k < 27; k++) send("R2 old entries cleared", mc_addr(k), 64);
        send("R2 new entry", mc_addr(90), 64);

        // R3: cap at 64 addresses
        mc_load(70 * 6, 70, 300);
        for (int k = 300; k < 372; k++) send("R3 cap at 64", mc_addr(k), 64);

        // R8: length boundary and floor
        send("R8 below minimum", 48'h0211_2233_4455, 59);
        send("R8 at minimum", 48'h0211_2233_4455, 60);
        cfg_write(7, 8'd2);
        send("R8 floor rejects 4", 48'h0211_2233_4455, 4);
        send("R8 floor accepts 5", 48'h0211_2233_4455, 5);

        // R4: promiscuous
        cfg_write(6, 8'h03);
        send("R4 promisc unicast", 48'h0A0B_0C0D_0E0F, 64);
        send("R4 promisc broadcast no flag", 48'hFFFF_FFFF_FFFF, 64);
        send("R4 promisc short", 48'h0A0B_0C0D_0E0F, 4);

        // R9: hold, extra bytes ignored, cleared after frm_start
        cfg_write(6, 8'h00);
        send("R9 decision", 48'h0211_2233_4455, 64);
        held = {dec_valid, dec_accept, dec_group};
        for (int j = 0; j < 4; j++) begin
            da_valid = 1'b1; da_byte = 8'hEE;
            @(negedge clk);
        end
        da_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 held after extra bytes", {dec_valid, dec_accept, dec_group}, held);
        frm_start = 1'b1; frm_len = 16'd64;
        @(negedge clk);
        frm_start = 1'b0;
        check("R9 cleared by frame start", {dec_valid, dec_accept, dec_group}, 3'b000);
        for (int b = 0; b < 5; b++) begin
            da_valid = 1'b1; da_byte = m_sta[47-8*b -: 8];
            @(negedge clk);
        end
        da_valid = 1'b0;
        check("R9 no decision after five bytes", {dec_valid, dec_accept, dec_group}, 3'b000);
        da_valid = 1'b1; da_byte = m_sta[7:0];
        @(negedge clk);
        da_valid = 1'b0;
        check("R9 decision after sixth byte", {dec_valid, dec_accept, dec_group}, 3'b110);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule